// File: doc/BRIEF.md
# Seven-to-one pixel lane serializer

This block turns a 28-bit parallel pixel word, presented once per pixel clock, into four serial data lanes that each carry seven bits per pixel. A fifth serial output carries a forwarded clock pattern at the pixel rate. The receiver uses this pattern to find the word boundary and to recover the bit clock. The block runs from two clocks. One is the pixel clock. The other is a bit clock at exactly seven times the pixel rate, with its rising edges aligned to the pixel clock's rising edges. The fast clock is produced outside the block, as are the line drivers.

The capture edge for the input word can be selected, so the block can follow sources that launch data on either pixel clock edge. A reduced-lane mode serves 18-bit colour formats. In that layout the low 18 data bits carry three 6-bit colour fields, bits 20 to 18 carry data enable and the two sync flags, and the top lane is not needed. That lane then idles at 0 and its seven input bits have no effect on any output.

Top module: `pixel_lane_serializer`

## Requirements
- R1: A new 28-bit word is captured on every pixel clock cycle. Lane k (k = 0..3) carries input bits din[7k+6:7k] of that word.
- R2: Each lane sends its seven bits in the seven bit-clock periods of one pixel period, starting with the most significant bit (din[7k+6]) and ending with din[7k].
- R3: fwd_clk_o follows the pattern 1,1,1,1,0,0,0 in every pixel period, which gives a 4:3 high-to-low ratio. The first 1 falls in the same bit period as the first bit of each word on the data lanes.
- R4: With rise_sel = 1, the word is sampled on the rising edge of pix_clk.
- R5: With rise_sel = 0, the word is sampled on the falling edge of pix_clk. It is sent in the same bit slots as a word sampled on the following rising edge.
- R6: With wide_en = 0, lane_o[3] stays at 0 and din[27:21] have no effect on any output. Lanes 0 to 2 are unaffected. With wide_en = 1, lane 3 works as in R1 and R2.
- R7: While rst_n is low, and after its release until the first word has been loaded, all lane outputs and fwd_clk_o are 0.
- R8: The latency is fixed. The first bit of a word sampled (or transferred, in falling-edge mode) at a pix_clk rising edge appears exactly one bit period after that edge. Successive words load exactly seven bit periods apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pix_clk | input | 1 | Pixel clock |
| bit_clk | input | 1 | Bit clock, seven times pix_clk, rising edges aligned |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| din | input | 28 | Parallel pixel word |
| rise_sel | input | 1 | 1: sample on rising pix_clk edge, 0: sample on falling edge |
| wide_en | input | 1 | 1: four data lanes, 0: lane 3 idle and its inputs ignored |
| lane_o | output | 4 | Serial data lanes, bit k is lane k |
| fwd_clk_o | output | 1 | Forwarded clock pattern lane |

## Verification
The bench changes din between the falling and the rising pixel edge. A design that took the wrong capture edge then sends the other word, and in rise_sel = 0 mode a design that skipped the falling-edge register sends the late value. Single-bit and asymmetric words show a lane swap, a reversed bit order or an off-by-one slot as a bit landing in the wrong lane or bit period. The bench also checks the forwarded pattern one bit period before and after each load, which exposes a load that is one bit early or late. With wide_en low it drives all ones into the top seven bits, so a lane 3 that still loads or leaks shows a 1. The reset checks look for outputs that toggle before the first real word arrives.

// File: rtl/pls_pkg.sv
`timescale 1ns/1ps
package pls_pkg;
  // Capture edge encoding for the rise_sel input
  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } cap_edge_e;
endpackage

// File: rtl/pls_rst_sync.sv
`timescale 1ns/1ps
module pls_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/pls_capture.sv
`timescale 1ns/1ps
module pls_capture
  import pls_pkg::*;
#(
  parameter int unsigned WORD_W = 28
) (
  input  logic              pix_clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] din,
  input  logic              rise_sel,
  output logic [WORD_W-1:0] word_o,
  output logic              tog_o
);
  logic [WORD_W-1:0] fall_q;
  logic [WORD_W-1:0] word_d, word_q;
  logic              tog_d, tog_q;

  // falling-edge sample, handed to the rising-edge register below
  always_ff @(negedge pix_clk or negedge rst_n) begin
    if (!rst_n) fall_q <= '0;
    else        fall_q <= din;
  end

  always_comb begin
    word_d = (cap_edge_e'(rise_sel) == EDGE_RISE) ? din : fall_q;
    tog_d  = ~tog_q;
  end

  always_ff @(posedge pix_clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      tog_q  <= 1'b0;
    end else begin
      word_q <= word_d;
      tog_q  <= tog_d;
    end
  end

  assign word_o = word_q;
  assign tog_o  = tog_q;

  AST_TOGGLE_RISE: assert property (@(posedge pix_clk) disable iff (!rst_n)
    !tog_q |=> tog_q); // R1
  AST_TOGGLE_FALL: assert property (@(posedge pix_clk) disable iff (!rst_n)
    tog_q |=> !tog_q); // R1
endmodule

// File: rtl/pls_frame.sv
`timescale 1ns/1ps
module pls_frame #(
  parameter int unsigned SLOT_W   = 7,
  parameter int unsigned CLK_HIGH = 4,
  localparam int unsigned CNT_W   = $clog2(SLOT_W)
) (
  input  logic bit_clk,
  input  logic rst_n,
  input  logic tog_i,
  output logic load_o,
  output logic clk_o
);
  logic             seen_q;
  logic [CNT_W-1:0] cnt_d, cnt_q;
  logic             run_d, run_q;
  logic             ck_d, ck_q;
  logic             load;

  // tog_i changes at a pixel edge; the next bit edge sees the change
  assign load = (tog_i != seen_q);

  always_comb begin
    run_d = run_q;
    if (load) begin
      cnt_d = '0;
      run_d = 1'b1;
    end else if (cnt_q == CNT_W'(SLOT_W - 1)) begin
      cnt_d = cnt_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
    ck_d = run_d && (cnt_d < CNT_W'(CLK_HIGH));
  end

  always_ff @(posedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      ck_q   <= 1'b0;
    end else begin
      seen_q <= tog_i;
      cnt_q  <= cnt_d;
      run_q  <= run_d;
      ck_q   <= ck_d;
    end
  end

  assign load_o = load;
  assign clk_o  = ck_q;

  AST_LOAD_ON_SLOT_END: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (load && run_q) |-> (cnt_q == CNT_W'(SLOT_W - 1))); // R8
  AST_CLK_HIGH_ON_LOAD: assert property (@(posedge bit_clk) disable iff (!rst_n)
    load |=> clk_o); // R3
  AST_QUIET_BEFORE_RUN: assert property (@(posedge bit_clk) disable iff (!rst_n)
    !run_q |-> !clk_o); // R7
endmodule

// File: rtl/pls_lane.sv
`timescale 1ns/1ps
module pls_lane #(
  parameter int unsigned SLOT_W = 7
) (
  input  logic              bit_clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              load_i,
  input  logic [SLOT_W-1:0] par_i,
  output logic              ser_o
);
  logic [SLOT_W-1:0] sh_d, sh_q;

  always_comb begin
    if (!en_i)       sh_d = '0;
    else if (load_i) sh_d = par_i;
    else             sh_d = {sh_q[SLOT_W-2:0], 1'b0};
  end

  always_ff @(posedge bit_clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign ser_o = sh_q[SLOT_W-1];

  AST_LANE_IDLE_ZERO: assert property (@(posedge bit_clk) disable iff (!rst_n)
    !en_i |=> !ser_o); // R6
  AST_LANE_MSB_FIRST: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (load_i && en_i) |=> (ser_o == $past(par_i[SLOT_W-1]))); // R2
endmodule

// File: rtl/pixel_lane_serializer.sv
`timescale 1ns/1ps
module pixel_lane_serializer #(
  parameter int unsigned NUM_LANES = 4,
  parameter int unsigned SLOT_W    = 7,
  parameter int unsigned CLK_HIGH  = 4
) (
  input  logic                          pix_clk,
  input  logic                          bit_clk,
  input  logic                          rst_n,
  input  logic [NUM_LANES*SLOT_W-1:0]   din,
  input  logic                          rise_sel,
  input  logic                          wide_en,
  output logic [NUM_LANES-1:0]          lane_o,
  output logic                          fwd_clk_o
);
  localparam int unsigned WORD_W       = NUM_LANES * SLOT_W;
  localparam int unsigned REDUCED_LANE = NUM_LANES - 1;
  // bit periods from the pixel rising edge to the first serial bit
  localparam int unsigned FIRST_BIT_LAT = 1;

  logic              pix_rst_n, bit_rst_n;
  logic [WORD_W-1:0] word;
  logic              tog;
  logic              load;

  pls_rst_sync u_pix_rst (.clk(pix_clk), .arst_n(rst_n), .srst_n(pix_rst_n));
  pls_rst_sync u_bit_rst (.clk(bit_clk), .arst_n(rst_n), .srst_n(bit_rst_n));

  pls_capture #(.WORD_W(WORD_W)) u_cap (
    .pix_clk  (pix_clk),
    .rst_n    (pix_rst_n),
    .din      (din),
    .rise_sel (rise_sel),
    .word_o   (word),
    .tog_o    (tog)
  );

  pls_frame #(.SLOT_W(SLOT_W), .CLK_HIGH(CLK_HIGH)) u_frame (
    .bit_clk (bit_clk),
    .rst_n   (bit_rst_n),
    .tog_i   (tog),
    .load_o  (load),
    .clk_o   (fwd_clk_o)
  );

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
    logic lane_en;
    if (k == REDUCED_LANE) begin : g_reduced
      assign lane_en = wide_en;
    end else begin : g_fixed
      assign lane_en = 1'b1;
    end
    pls_lane #(.SLOT_W(SLOT_W)) u_lane (
      .bit_clk (bit_clk),
      .rst_n   (bit_rst_n),
      .en_i    (lane_en),
      .load_i  (load),
      .par_i   (word[k*SLOT_W +: SLOT_W]),
      .ser_o   (lane_o[k])
    );
  end

  AST_RESET_QUIET: assert property (@(posedge bit_clk)
    !bit_rst_n |=> (lane_o == '0 && !fwd_clk_o)); // R7
  AST_LATENCY_ONE: assert property (@(posedge bit_clk) disable iff (!bit_rst_n)
    load |=> (FIRST_BIT_LAT == 1 && fwd_clk_o)); // R8
endmodule

// File: tb/tb_pixel_lane_serializer.sv
`timescale 1ns/1ps
module tb_pixel_lane_serializer;
  logic        bit_clk, pix_clk, rst_n, rise_sel, wide_en;
  logic [27:0] din;
  logic [3:0]  lane_o;
  logic        fwd_clk_o;
  int          n_chk, n_bad;
  bit          done;

  pixel_lane_serializer dut (
    .pix_clk   (pix_clk),
    .bit_clk   (bit_clk),
    .rst_n     (rst_n),
    .din       (din),
    .rise_sel  (rise_sel),
    .wide_en   (wide_en),
    .lane_o    (lane_o),
    .fwd_clk_o (fwd_clk_o)
  );

  // 50 MHz bit clock, pixel clock at one seventh, rising edges aligned
  initial begin bit_clk = 1'b0; forever #10 bit_clk = ~bit_clk; end
  initial begin pix_clk = 1'b0; forever #70 pix_clk = ~pix_clk; end

  task automatic check(string req, logic [4:0] act, logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // early word held across the falling edge, late word across the rising edge
  task automatic run_word(string req, logic [27:0] w_early, logic [27:0] w_late,
                          bit rise, bit wide);
    logic [27:0] w;
    logic [4:0]  e;
    @(posedge pix_clk); #5;
    rise_sel = rise; wide_en = wide; din = w_early;
    #100;
    din = w_late;
    w = rise ? w_late : w_early;
    @(posedge pix_clk);
    #10;
    check({req, " R8 pre-load slot"}, {fwd_clk_o, 4'b0}, 5'b0);
    #20;
    for (int j = 0; j < 7; j++) begin
      e[4] = (j < 4);
      for (int k = 0; k < 4; k++) e[k] = w[7*k+6-j] && (k < 3 || wide);
      check(req, {fwd_clk_o, lane_o}, e);
      #20;
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0; rise_sel = 1'b1; wide_en = 1'b1; din = 28'hFFFFFFF;
    #300;
    check("R7 in reset", {fwd_clk_o, lane_o}, 5'b0);
    #705;
    rst_n = 1'b1;
    #295;
    check("R7 after release before load", {fwd_clk_o, lane_o}, 5'b0);
  endtask

  task automatic t_patterns;
    run_word("R1 R2 R3 mixed", 28'hA5C3F0E, 28'hA5C3F0E, 1'b1, 1'b1);
    run_word("R2 lane0 lsb", 28'h0000001, 28'h0000001, 1'b1, 1'b1);
    run_word("R2 lane3 msb", 28'h8000000, 28'h8000000, 1'b1, 1'b1);
    run_word("R1 walking", 28'h1020408, 28'h1020408, 1'b1, 1'b1);
    run_word("R1 back to back", 28'h5555555, 28'h5555555, 1'b1, 1'b1);
  endtask

  task automatic t_edges;
    run_word("R4 rising capture", 28'h0F0F0F0, 28'h3C96E1B, 1'b1, 1'b1);
    run_word("R5 falling capture", 28'h0F0F0F0, 28'h3C96E1B, 1'b0, 1'b1);
    run_word("R5 falling capture 2", 28'h7FFFFFF, 28'h0000000, 1'b0, 1'b1);
  endtask

  task automatic t_reduced;
    run_word("R6 lane3 idle", 28'hFE12345, 28'hFE12345, 1'b1, 1'b0);
    run_word("R6 lane3 idle falling", 28'hFE00000, 28'hFE00000, 1'b0, 1'b0);
    run_word("R6 lane3 restored", 28'hFE12345, 28'hFE12345, 1'b1, 1'b1);
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    t_reset();
    t_patterns();
    t_edges();
    t_reduced();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule